// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: the address-latch strobe, which tells outside logic when to capture the low address byte, and the active-low program-read strobe, which gates bytes fetched from external program memory. Both strobes are decoded from a machine-cycle phase counter. The counter runs on the oscillator clock and divides each machine cycle into twelve oscillator periods, which form six states of two periods each.

The address-latch strobe normally pulses twice per machine cycle. The program-read strobe pulses twice per machine cycle, but only while code is fetched from outside the chip. The sequencer raises a flag for each machine cycle that performs an external data access. In such a cycle the second latch pulse and both program-read pulses are suppressed. The sequencer can also set a disable bit that holds the latch strobe off and asks the pad for its weak pullup. Certain operating conditions override this bit.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Configuration writes take effect on the clock edge on which they are presented.

Top module: `sg_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale` and `ale_pullup` are low, `prog_rd_n` is high and the disable bit is cleared. At the first rising clock edge after reset is released, the block starts at phase 0. Each later edge advances the phase by one, modulo 12.
- R2: `ale` is high in phases 0, 1, 6 and 7 and low in all other phases. This gives one two-period pulse every six oscillator periods.
- R3: With `ext_exec` high, `prog_rd_n` is low in phases 3, 4, 5, 9, 10 and 11. This gives two activations per machine cycle.
- R4: `xdata_cycle` is sampled in phase 11 and marks the following machine cycle as a data-access cycle. In that cycle the `ale` pulse of phases 6–7 is omitted and the pulse of phases 0–1 is kept.
- R5: In a data-access machine cycle, both `prog_rd_n` activations are omitted. With `ext_exec` low, `prog_rd_n` stays high.
- R6: A write (`cfg_we` high) with `cfg_wdata` bit 0 set stores the disable bit. While the bit takes effect, `ale` is held low and `ale_pullup` is high.
- R7: If any of `insn_xmove`, `insn_cmove`, `idle_mode`, `pdown_mode` or `emu_mode` is high, the stored disable bit is suspended. `ale` then follows R2 and R4, and `ale_pullup` is low.
- R8: While `ext_exec` is high, the stored disable bit has no effect: `ale` follows R2 and R4, and `ale_pullup` is low.
- R9: A write with `cfg_wdata` bit 0 clear, or a reset, clears the disable bit. Bits 7 to 1 of `cfg_wdata` are ignored.
- R10: `ale` high and `prog_rd_n` low never occur in the same oscillator period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the strobe control byte |
| cfg_wdata | input | 8 | Control byte; bit 0 is the latch-strobe disable |
| ext_exec | input | 1 | Code is being fetched from external program memory |
| xdata_cycle | input | 1 | Next machine cycle accesses external data memory (sampled in phase 11) |
| insn_xmove | input | 1 | Current instruction moves external data |
| insn_cmove | input | 1 | Current instruction reads from code memory |
| idle_mode | input | 1 | Idle power mode active |
| pdown_mode | input | 1 | Power-down mode active |
| emu_mode | input | 1 | Emulation mode active |
| ale | output | 1 | Address-latch strobe, active high |
| prog_rd_n | output | 1 | Program-read strobe, active low |
| ale_pullup | output | 1 | Request for the weak pullup on the latch-strobe pad |

## Verification
The bench runs all 64 combinations of the five suspension inputs and `ext_exec` while the disable bit is set. A design that ignored one of the overrides would hold `ale` low or raise `ale_pullup` in one of these combinations. Data-access cycles are mixed with normal cycles, and strobe edges are counted per machine cycle. A design that dropped the wrong latch pulse, sampled `xdata_cycle` in the wrong phase, or suppressed only one program-read pulse would show the wrong count or the wrong phase. Further checks cover a write with only upper bits set, a clearing write and a reset. These catch a disable bit that decodes the wrong bit or survives reset.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int DIS_BIT = 0;

  typedef struct packed {
    logic xmove;
    logic cmove;
    logic idle;
    logic pdown;
    logic emu;
  } susp_t;
endpackage

// File: rtl/sg_phase_ctr.sv
module sg_phase_ctr #(
  parameter int OSC_PER_MC = 12,
  localparam int W = $clog2(OSC_PER_MC)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         run,
  output logic [W-1:0] phase,
  output logic         mc_last
);
  localparam logic [W-1:0] LAST = W'(OSC_PER_MC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
    end else begin
      run <= 1'b1;
      if (run) phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign mc_last = run && (phase == LAST);
endmodule

// File: rtl/sg_cycle_class.sv
module sg_cycle_class (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_last,
  input  logic xdata_cycle,
  output logic mc_is_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mc_is_data <= 1'b0;
    else if (mc_last) mc_is_data <= xdata_cycle;
  end
endmodule

// File: rtl/sg_ale_ctrl.sv
module sg_ale_ctrl
  import sg_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  susp_t            susp,
  input  logic             ext_exec,
  output logic             dis_eff
);
  logic dis_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dis_bit <= 1'b0;
    else if (cfg_we) dis_bit <= cfg_wdata[DIS_BIT];
  end

  // Any override condition suspends the stored disable
  assign dis_eff = dis_bit && !(|susp) && !ext_exec;
endmodule

// File: rtl/sg_strobe_gen.sv
module sg_strobe_gen
  import sg_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int ALE_W      = 2,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ext_exec,
  input  logic             xdata_cycle,
  input  logic             insn_xmove,
  input  logic             insn_cmove,
  input  logic             idle_mode,
  input  logic             pdown_mode,
  input  logic             emu_mode,
  output logic             ale,
  output logic             prog_rd_n,
  output logic             ale_pullup
);
  localparam int W      = $clog2(OSC_PER_MC);
  localparam int HALF   = OSC_PER_MC / 2;
  localparam int RD_BEG = HALF / 2;

  logic         run, mc_last, mc_is_data, dis_eff;
  logic [W-1:0] phase, hph;
  logic         in_second, ale_win, rd_win;
  susp_t        susp;

  sg_phase_ctr #(.OSC_PER_MC(OSC_PER_MC)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .mc_last(mc_last)
  );

  sg_cycle_class u_cls (
    .clk(clk), .rst_n(rst_n), .mc_last(mc_last),
    .xdata_cycle(xdata_cycle), .mc_is_data(mc_is_data)
  );

  assign susp = '{xmove: insn_xmove, cmove: insn_cmove, idle: idle_mode,
                  pdown: pdown_mode, emu: emu_mode};

  sg_ale_ctrl #(.CFG_W(CFG_W)) u_ale (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .susp(susp), .ext_exec(ext_exec), .dis_eff(dis_eff)
  );

  // Phase decode within each half machine cycle
  always_comb begin
    in_second = (phase >= W'(HALF));
    hph       = in_second ? phase - W'(HALF) : phase;
    ale_win   = (hph < W'(ALE_W));
    rd_win    = (hph >= W'(RD_BEG));
  end

  assign ale        = run && ale_win && !(mc_is_data && in_second) && !dis_eff;
  assign prog_rd_n  = !(run && ext_exec && rd_win && !mc_is_data);
  assign ale_pullup = run && dis_eff;
endmodule

// File: rtl/sg_strobe_chk.sv
module sg_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cfg_wdata0,
  input logic ext_exec,
  input logic insn_xmove,
  input logic insn_cmove,
  input logic idle_mode,
  input logic pdown_mode,
  input logic emu_mode,
  input logic ale,
  input logic prog_rd_n,
  input logic ale_pullup
);
  AST_RD_INTERNAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec |-> prog_rd_n); // R5
  AST_PULLUP_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_pullup |-> !ale); // R6
  AST_SUSPEND_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_xmove || insn_cmove || idle_mode || pdown_mode || emu_mode) |-> !ale_pullup); // R7
  AST_EXTEXEC_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_exec |-> !ale_pullup); // R8
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata0) |=> !ale_pullup); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !prog_rd_n)); // R10
endmodule

bind sg_strobe_gen sg_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata0(cfg_wdata[0]),
  .ext_exec(ext_exec), .insn_xmove(insn_xmove), .insn_cmove(insn_cmove),
  .idle_mode(idle_mode), .pdown_mode(pdown_mode), .emu_mode(emu_mode),
  .ale(ale), .prog_rd_n(prog_rd_n), .ale_pullup(ale_pullup)
);

// File: tb/tb_sg_strobe_gen.sv
`timescale 1ns/1ps
module tb_sg_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic ext_exec = 1'b0, xdata_cycle = 1'b0;
  logic insn_xmove = 1'b0, insn_cmove = 1'b0, idle_mode = 1'b0;
  logic pdown_mode = 1'b0, emu_mode = 1'b0;
  logic ale, prog_rd_n, ale_pullup;

  int tests = 0, fails = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sg_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_exec(ext_exec), .xdata_cycle(xdata_cycle), .insn_xmove(insn_xmove),
    .insn_cmove(insn_cmove), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .emu_mode(emu_mode), .ale(ale), .prog_rd_n(prog_rd_n), .ale_pullup(ale_pullup)
  );

  // Arithmetic expectation of phase, cycle class and disable bit
  bit m_run = 0, m_dat = 0, m_dis = 0;
  int m_ph = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_dat = 0; m_dis = 0;
    end else begin
      if (m_run) begin
        if (m_ph == 11) m_dat = xdata_cycle;
        m_ph = (m_ph + 1) % 12;
      end
      m_run = 1;
      if (cfg_we) m_dis = cfg_wdata[0];
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at t=%0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  int ale_rises = 0, rd_falls = 0;
  logic prev_ale = 1'b0, prev_rd = 1'b1;
  always @(negedge clk) begin
    if (chk_en) begin
      bit susp, eff, e_ale, e_rd, e_pu;
      int hp;
      string ta, tr;
      susp  = insn_xmove | insn_cmove | idle_mode | pdown_mode | emu_mode;
      eff   = m_dis && !susp && !ext_exec;
      hp    = m_ph % 6;
      e_ale = m_run && (hp < 2) && !(m_dat && m_ph >= 6) && !eff;
      e_rd  = !(m_run && ext_exec && hp >= 3 && !m_dat);
      e_pu  = m_run && eff;
      if (!m_run)                ta = "R1";
      else if (m_dis && ext_exec) ta = "R8";
      else if (m_dis && susp)     ta = "R7";
      else if (m_dis)             ta = "R6";
      else if (m_dat)             ta = "R4";
      else                        ta = "R2";
      if (!m_run)                  tr = "R1";
      else if (!ext_exec || m_dat) tr = "R5";
      else                         tr = "R3";
      check(ta, "ale", ale, e_ale);
      check(tr, "prog_rd_n", prog_rd_n, e_rd);
      check((m_run && !m_dis) ? "R9" : ta, "ale_pullup", ale_pullup, e_pu);
      check("R10", "overlap", ale && !prog_rd_n, 1'b0);
      if (ale && !prev_ale) ale_rises++;
      if (!prog_rd_n && prev_rd) rd_falls++;
    end
    prev_ale = ale;
    prev_rd  = prog_rd_n;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    cycles(1);
    cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  initial begin
    // R1: reset state
    cycles(2);
    chk_en = 1'b1;
    cycles(3);
    #1 rst_n = 1'b1;
    cycles(24);
    // R3: external execution, two read pulses per machine cycle
    ext_exec = 1'b1;
    cycles(36);
    // R4, R5: alternating data-access machine cycles
    for (int mc = 0; mc < 8; mc++) begin
      xdata_cycle = mc[0];
      cycles(12);
    end
    xdata_cycle = 1'b0;
    cycles(24);
    // Edge counts over ten normal machine cycles (R2, R3)
    ale_rises = 0; rd_falls = 0;
    cycles(120);
    check("R2", "ale pulses per 10 cycles", ale_rises == 20, 1'b1);
    check("R3", "read pulses per 10 cycles", rd_falls == 20, 1'b1);
    // Edge counts over ten data-access machine cycles (R4, R5)
    xdata_cycle = 1'b1;
    cycles(12);
    ale_rises = 0; rd_falls = 0;
    cycles(120);
    check("R4", "ale pulses in data cycles", ale_rises == 10, 1'b1);
    check("R5", "read pulses in data cycles", rd_falls == 0, 1'b1);
    xdata_cycle = 1'b0;
    ext_exec = 1'b0;
    cycles(24);
    // R9: upper bits only do not disable
    write_cfg(8'hFE);
    cycles(12);
    // R6: disable takes effect
    write_cfg(8'h01);
    cycles(24);
    // R7, R8: all override combinations with the disable set
    for (int c = 0; c < 64; c++) begin
      {ext_exec, insn_xmove, insn_cmove, idle_mode, pdown_mode, emu_mode} = 6'(c);
      xdata_cycle = c[3];
      cycles(12);
    end
    {ext_exec, insn_xmove, insn_cmove, idle_mode, pdown_mode, emu_mode} = 6'd0;
    xdata_cycle = 1'b0;
    cycles(24);
    // R9: clearing write
    write_cfg(8'hFE);
    cycles(24);
    // R9: reset clears a set disable bit
    write_cfg(8'h01);
    cycles(12);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(24);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule